// File: doc/BRIEF.md
# Serial Flash Status and Write-Protection Controller

This block holds the status byte of a serial flash slave and decides, for every write-class instruction, whether the instruction may proceed. It keeps five status bits:

- a busy flag;
- a write-enable latch;
- a two-bit protection-size field;
- a lock bit that works together with an external write-protect pin.

Instructions arrive already decoded from the serial front end as a one-cycle `cmd_valid` strobe with an operation code, an array address and a data byte. The block answers in one of two ways:

- It launches an array operation with a one-cycle `array_start` pulse.
- It refuses the operation with a one-cycle `cmd_reject` pulse.

While a status write, program or erase cycle runs, the busy flag is high for a parameterised number of clocks. It can be polled at any time on `status`.

The controller is a three-state machine:

- `ST_IDLE` accepts instructions.
- `ST_SR_BUSY` times a status-register write and commits the new protection bits on its last clock.
- `ST_ARR_BUSY` times a program or erase.

The transitions are:

- `ST_IDLE` to `ST_SR_BUSY` when a status write is accepted.
- `ST_IDLE` to `ST_ARR_BUSY` when a program or erase is accepted.
- Either busy state back to `ST_IDLE` when the cycle timer expires.

The non-volatile bits are modelled as flops whose reset value is a parameter.

Top module: `flash_status_ctrl`

## Requirements
- R1: `status` reads {lock, 3'b000, bp[1:0], wel, wip}: bit0 busy, bit1 write-enable latch, bits 3:2 protection size, bits 6:4 always 0, bit7 lock. After reset, wip and wel are 0 and bits 7,3:2 equal the parameter NV_RESET (default 0).
- R2: Operation codes on `cmd_op` are 0 none, 1 write-enable, 2 write-disable, 3 status write, 4 program, 5 sector erase, 6 bulk erase. In idle, write-enable sets wel and write-disable clears it, both on the clock after the strobe.
- R3: A status write, program or either erase issued while wel is 0 has no effect: no pulse, no busy cycle, status unchanged.
- R4: `addr_protected` reports for `cmd_addr`: bp=00 nothing protected; bp=01 the upper half (address MSB set); bp=10 or 11 every address.
- R5: A program or sector erase with wel set whose address is protected is refused. `cmd_reject` pulses on the next clock, wel clears, and no busy cycle starts.
- R6: An accepted program or erase pulses `array_start` on the next clock. wip then stays 1 for PROG_CYCLES (program) or ERASE_CYCLES (erase) clocks, after which wip and wel both read 0.
- R7: An accepted status write holds wip for SR_CYCLES clocks, then loads lock from data bit 7 and bp from data bits 3:2, and clears wel. All other data bits are ignored.
- R8: `hw_protected` is lock AND NOT `wp_n`. While it is 1, a status write with wel set is refused: `cmd_reject` pulses, wel clears, and bits 7,3:2 keep their value.
- R9: While wip is 1, every instruction is ignored, including one that coincides with the last busy clock.
- R10: A bulk erase with wel set is refused (as in R5) whenever bp is not 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_n | input | 1 | Write-protect pin, active low |
| cmd_valid | input | 1 | One-cycle decoded instruction strobe |
| cmd_op | input | 3 | Operation code (see R2) |
| cmd_addr | input | ADDR_W | Target array address |
| cmd_wdata | input | 8 | Data byte for a status write |
| status | output | 8 | Status byte (see R1) |
| array_start | output | 1 | Pulse: array program/erase launched |
| cmd_reject | output | 1 | Pulse: instruction refused by protection |
| hw_protected | output | 1 | Hardware-protected mode active |
| addr_protected | output | 1 | `cmd_addr` lies in the protected area |

## Verification
Two functions can coincide in one clock: the end of a busy cycle, which clears wip and wel and may commit new protection bits, and the arrival of a new instruction. The bench provokes this by holding a write-disable strobe for the whole of a program cycle, including the clock on which the timer expires. It also sends a status write during a busy window. It judges the result by requiring that wel stays 1 while wip is 1, that wel falls only because the cycle completed, and that the protection bits read afterwards are unchanged.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_WREN   = 3'd1,
        OP_WRDIS  = 3'd2,
        OP_WRSTAT = 3'd3,
        OP_PROG   = 3'd4,
        OP_SERASE = 3'd5,
        OP_BERASE = 3'd6
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SR_BUSY  = 2'd1,
        ST_ARR_BUSY = 2'd2
    } state_e;

    localparam int STAT_W = 8;

endpackage

// File: rtl/fsr_protect_map.sv
module fsr_protect_map #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        bp,
    input  logic              whole_array,
    output logic              prot
);
    localparam int MSB = ADDR_W - 1;

    always_comb begin
        if (whole_array) begin
            prot = (bp != 2'b00);
        end else begin
            unique case (bp)
                2'b00:   prot = 1'b0;
                2'b01:   prot = addr[MSB];
                default: prot = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/fsr_cycle_timer.sv
module fsr_cycle_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expire = (cnt == '0);
endmodule

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
    import flash_sr_pkg::*;
#(
    parameter int          ADDR_W       = 16,
    parameter int          SR_CYCLES    = 4,
    parameter int          PROG_CYCLES  = 6,
    parameter int          ERASE_CYCLES = 10,
    parameter logic [2:0]  NV_RESET     = 3'b000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_wdata,
    output logic [7:0]        status,
    output logic              array_start,
    output logic              cmd_reject,
    output logic              hw_protected,
    output logic              addr_protected
);
    localparam int MAX_CYC = (ERASE_CYCLES > PROG_CYCLES) ?
                             ((ERASE_CYCLES > SR_CYCLES) ? ERASE_CYCLES : SR_CYCLES) :
                             ((PROG_CYCLES > SR_CYCLES) ? PROG_CYCLES : SR_CYCLES);
    localparam int CNT_W = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] SR_LOAD    = CNT_W'(SR_CYCLES - 1);
    localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYCLES - 1);
    localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYCLES - 1);

    state_e           state, state_nx;
    logic             wel;
    logic [1:0]       bp;
    logic             lock;
    logic [2:0]       pend_nv;
    logic             wip;
    logic             expire;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             set_wel, clr_wel, go_sr, go_arr, refuse;
    op_e              op;

    assign op           = op_e'(cmd_op);
    assign wip          = (state != ST_IDLE);
    assign hw_protected = lock & ~wp_n;
    assign status       = {lock, 3'b000, bp, wel, wip};

    fsr_protect_map #(.ADDR_W(ADDR_W)) u_map (
        .addr        (cmd_addr),
        .bp          (bp),
        .whole_array (op == OP_BERASE),
        .prot        (addr_protected)
    );

    fsr_cycle_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (expire)
    );

    // instruction decision and next state
    always_comb begin
        set_wel  = 1'b0;
        clr_wel  = 1'b0;
        go_sr    = 1'b0;
        go_arr   = 1'b0;
        refuse   = 1'b0;
        tmr_val  = PROG_LOAD;
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    unique case (op)
                        OP_WREN:   set_wel = 1'b1;
                        OP_WRDIS:  clr_wel = 1'b1;
                        OP_WRSTAT: begin
                            if (wel && hw_protected) refuse = 1'b1;
                            else if (wel)            go_sr  = 1'b1;
                        end
                        OP_PROG, OP_SERASE, OP_BERASE: begin
                            if (wel && addr_protected) refuse = 1'b1;
                            else if (wel)              go_arr = 1'b1;
                        end
                        default: ;
                    endcase
                end
                if (go_sr) begin
                    state_nx = ST_SR_BUSY;
                    tmr_val  = SR_LOAD;
                end else if (go_arr) begin
                    state_nx = ST_ARR_BUSY;
                    tmr_val  = (op == OP_PROG) ? PROG_LOAD : ERASE_LOAD;
                end
            end
            ST_SR_BUSY, ST_ARR_BUSY: begin
                if (expire) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign tmr_load = go_sr | go_arr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // register bits and pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel         <= 1'b0;
            {lock, bp}  <= NV_RESET;
            pend_nv     <= NV_RESET;
            array_start <= 1'b0;
            cmd_reject  <= 1'b0;
        end else begin
            array_start <= go_arr;
            cmd_reject  <= refuse;
            if (go_sr) pend_nv <= {cmd_wdata[7], cmd_wdata[3:2]};
            if (wip && expire) begin
                wel <= 1'b0;
                if (state == ST_SR_BUSY) {lock, bp} <= pend_nv;
            end else if (set_wel) begin
                wel <= 1'b1;
            end else if (clr_wel || refuse) begin
                wel <= 1'b0;
            end
        end
    end

    // ---------------- assertions ----------------
    assert_busy_needs_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(wel && cmd_valid));

    assert_reject_clears_wel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reject |-> (!wel && !wip));

    assert_start_is_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        array_start |-> (wip && wel));

    assert_pulses_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({array_start, cmd_reject}));

    assert_hw_lock_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_protected && !wip) |=> $stable({lock, bp}));

    assert_wel_held_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wip && !expire) |=> $stable(wel));

    assert_bulk_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !wip && wel && op == OP_BERASE && bp != 2'b00) |=> cmd_reject);

    assert_status_zero_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
        status[6:4] == 3'b000);
endmodule

// File: tb/tb_flash_status_ctrl.sv
module tb_flash_status_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N = 27;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wp_n = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [15:0] cmd_addr = 16'h0;
    logic [7:0]  cmd_wdata = 8'h0;
    logic [7:0]  status;
    logic        array_start, cmd_reject, hw_protected, addr_protected;

    int checks = 0;
    int errors = 0;

    flash_status_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .status(status), .array_start(array_start), .cmd_reject(cmd_reject),
        .hw_protected(hw_protected), .addr_protected(addr_protected)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ops: 1 wren, 2 wrdis, 3 status write, 4 program, 5 sector erase, 6 bulk erase
    localparam logic        V_WP  [N] = '{1,1,1,1,1,1,1,1,1,1,1,1,1,0,0,0,0,1,1,1,1,1,1,1,1,1,1};
    localparam logic [2:0]  V_OP  [N] = '{4,1,2,1,4,1,3,1,4,1,4,1,6,1,3,1,4,1,3,1,5,1,3,1,6,1,5};
    localparam logic [15:0] V_AD  [N] = '{16'h8000,0,0,0,16'h8000,0,0,0,16'h8000,0,16'h1000,0,0,
                                          0,0,0,16'h0010,0,0,0,16'h0000,0,0,0,0,0,16'h8000};
    localparam logic [7:0]  V_WD  [N] = '{0,0,0,0,0,0,8'hF7,0,0,0,0,0,0,0,8'h00,0,0,0,8'h08,0,0,0,8'h00,0,0,0,0};
    localparam logic        V_ST  [N] = '{0,0,0,0,1,0,0,0,0,0,1,0,0,0,0,0,1,0,0,0,0,0,0,0,1,0,1};
    localparam logic        V_RJ  [N] = '{0,0,0,0,0,0,0,0,1,0,0,0,1,0,1,0,0,0,0,0,1,0,0,0,0,0,0};
    localparam int          V_BSY [N] = '{0,0,0,0,6,0,4,0,0,0,6,0,0,0,0,0,6,0,4,0,0,0,4,0,10,0,10};
    localparam logic [7:0]  V_STS [N] = '{8'h00,8'h02,8'h00,8'h02,8'h00,8'h02,8'h84,8'h86,8'h84,8'h86,
                                          8'h84,8'h86,8'h84,8'h86,8'h84,8'h86,8'h84,8'h86,8'h08,8'h0A,
                                          8'h08,8'h0A,8'h00,8'h02,8'h00,8'h02,8'h00};

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [15:0] ad, input logic [7:0] wd);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = ad; cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic drain();
        int guard = 0;
        while (status[0] && guard < 100) begin
            guard++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD*30000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", status, 8'h00, "status after reset");
        check("R8", hw_protected, 0, "hw_protected after reset");
        rst_n = 1'b1;
        @(negedge clk);

        // vector table
        for (int i = 0; i < N; i++) begin
            int busy;
            wp_n = V_WP[i];
            issue(V_OP[i], V_AD[i], V_WD[i]);
            check("R6", array_start, V_ST[i], $sformatf("array_start row %0d", i));
            check("R5", cmd_reject, V_RJ[i], $sformatf("cmd_reject row %0d", i));
            busy = 0;
            while (status[0] && busy < 100) begin
                busy++;
                @(negedge clk);
            end
            check("R7", busy, V_BSY[i], $sformatf("busy clocks row %0d (R6/R7)", i));
            check("R2", status, V_STS[i], $sformatf("status row %0d (R3/R8/R10)", i));
            check("R8", hw_protected, V_STS[i][7] & ~V_WP[i], $sformatf("hw_protected row %0d", i));
        end

        // R4 protection map with bp=01
        wp_n = 1'b1;
        issue(3'd1, 0, 0);
        issue(3'd3, 0, 8'h04);
        drain();
        check("R7", status, 8'h04, "bp=01 loaded");
        @(negedge clk);
        cmd_op = 3'd4; cmd_addr = 16'h8000; #1;
        check("R4", addr_protected, 1, "bp=01 upper half");
        cmd_addr = 16'h7FFF; #1;
        check("R4", addr_protected, 0, "bp=01 lower half");
        cmd_op = 3'd6; #1;
        check("R10", addr_protected, 1, "bulk with bp=01");
        cmd_op = 3'd0;

        // R9: write-disable held across whole program cycle, incl. last clock
        issue(3'd1, 0, 0);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd4; cmd_addr = 16'h0100;
        @(negedge clk);
        cmd_op = 3'd2;
        while (status[0]) begin
            check("R9", status[1], 1, "wel held while busy");
            @(negedge clk);
        end
        cmd_valid = 1'b0; cmd_op = 3'd0;
        check("R9", status, 8'h04, "status after busy with strobes");

        // R9: status write during busy ignored
        issue(3'd1, 0, 0);
        issue(3'd4, 16'h0200, 0);
        issue(3'd3, 0, 8'h8C);
        drain();
        check("R9", status, 8'h04, "status write while busy ignored");

        // reset again: bits return to parameter value
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", status, 8'h00, "status after second reset");
        rst_n = 1'b1;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule